// File: doc/BRIEF.md
# Bit-Serial CRC-32 Engine for Ethernet Frames

This block works out the Ethernet CRC-32 one bit per clock while a short message moves across a serial link. The sender or receiver gives a one-cycle start pulse together with the message length in bits and a mode select. It then offers one data bit per cycle with a qualifier. The engine keeps only a 32-bit linear feedback shift register and a bit counter. No message buffer, no zero padding and no realignment of a maximum-length word are needed, because each bit is folded into the register as it arrives. The engine stops taking bits by itself once the programmed count has been reached.

In transmit mode the engine takes exactly the message bits, then presents the inverted register as the check word. That word is sent on the wire with its bit 31 first. In receive mode the engine takes the message bits followed by the 32 check bits. It then reports whether the register has reached the fixed residue that every error-free frame produces.

Top module: `crc32_serial_engine`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done` and `crc_ok` are 0 and `crc_out` reads 0x00000000, because the register is held at all ones and `crc_out` is its inverse.
- R2: The clock edge that samples `start` high sets the register to all ones, so `crc_out` reads 0 in the next cycle. The same edge raises `busy` and captures `msg_len` and `rx_mode_sel`. This holds whether or not a message was already in progress.
- R3: A bit is accepted on an edge where `busy` and `bit_vld` are high and `start` is low. Each accepted bit shifts the register left by one. The feedback, formed as register bit 31 XOR `bit_in`, is XORed into the taps of polynomial 0x04C11DB7. The first bit on the wire enters first.
- R4: In transmit mode (`rx_mode_sel`=0) the engine accepts exactly the clamped `msg_len` bits. `done` is high for one cycle, starting one cycle after the edge that accepted the last bit. At that point `busy` is low and `crc_out` holds the inverted register, which is sent with bit 31 first.
- R5: In receive mode (`rx_mode_sel`=1) the engine accepts the clamped length plus 32 bits. When `done` is raised, `crc_ok` is 1 exactly when the register equals 0xC704DD7B. `crc_ok` keeps that value until the next start.
- R6: Bits offered while `busy` is low, including bits that follow the last counted bit, have no effect. `crc_out` stays unchanged and no further `done` appears.
- R7: Cycles with `bit_vld` low during a message leave the register and the count unchanged, so gaps do not change the result.
- R8: A `msg_len` below 12 is treated as 12 and one above 64 is treated as 64.
- R9: A start pulse during a message drops the partial result, and the new message is computed from the preset.
- R10: `crc_ok` stays 0 after a transmit-mode message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a message |
| rx_mode_sel | input | 1 | Mode sampled at start: 0 transmit, 1 receive |
| msg_len | input | 7 | Message length in bits, sampled at start |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` |
| busy | output | 1 | High while bits are still expected |
| done | output | 1 | One-cycle pulse after the last bit |
| crc_ok | output | 1 | Receive result: the residue matched |
| crc_out | output | 32 | Inverted register; the check word after a transmit message |

## Verification
The preset shows at the ports one cycle after the start edge. `done`, the final `crc_out` and `crc_ok` all appear one cycle after the edge that consumed the last bit, since each passes through exactly one register. The bench drives inputs on falling edges and samples outputs on the falling edge right after the consuming rising edge. This places every result check in the first cycle where the value is due, and a check one cycle later confirms that `done` has dropped. Stalls, overrun bits and idle bits are checked cycle by cycle against a `crc_out` that must not move.

// File: rtl/crc32_serial_pkg.sv
package crc32_serial_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

  // Clamp a requested length into the legal message range.
  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] state,
  output logic [W-1:0] state_nxt
);

  logic fb;
  assign fb = state[W-1] ^ din;

  // Tap network: one XOR per set polynomial bit.
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign state_nxt[i] = POLY[i] & fb;
    end else if (POLY[i]) begin : g_xor
      assign state_nxt[i] = state[i-1] ^ fb;
    end else begin : g_pass
      assign state_nxt[i] = state[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     state <= PRESET;
    else if (load)  state <= PRESET;
    else if (shift) state <= state_nxt;
  end

endmodule

// File: rtl/crc_len_tracker.sv
module crc_len_tracker #(
  parameter int MIN_BITS  = 12,
  parameter int MAX_BITS  = 64,
  parameter int TAIL_BITS = 32,
  parameter int LEN_W     = 7,
  localparam int CNT_W    = $clog2(MAX_BITS + TAIL_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_req,
  input  logic [LEN_W-1:0] len_req,
  input  logic             take,
  output logic             busy,
  output logic             rx_mode,
  output logic             last_take
);
  import crc32_serial_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] target_req;

  always_comb begin
    target_req = CNT_W'(clamp_len(int'(len_req), MIN_BITS, MAX_BITS));
    if (rx_req) target_req = target_req + CNT_W'(TAIL_BITS);
  end

  assign last_take = take && (cnt == target - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rx_mode <= 1'b0;
      cnt     <= '0;
      target  <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      rx_mode <= rx_req;
      cnt     <= '0;
      target  <= target_req;
    end else if (take) begin
      cnt <= cnt + CNT_W'(1);
      if (last_take) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/crc_result_stage.sv
module crc_result_stage #(
  parameter int W = 32,
  parameter logic [W-1:0] RESIDUE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         last_take,
  input  logic         rx_mode,
  input  logic [W-1:0] state_nxt,
  output logic         done,
  output logic         crc_ok
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      crc_ok <= 1'b0;
    end else begin
      done <= last_take;
      if (start)          crc_ok <= 1'b0;
      else if (last_take) crc_ok <= rx_mode && (state_nxt == RESIDUE);
    end
  end

endmodule

// File: rtl/crc32_serial_engine.sv
module crc32_serial_engine #(
  parameter int MIN_MSG_BITS = 12,
  parameter int MAX_MSG_BITS = 64,
  parameter int LEN_W = $clog2(MAX_MSG_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_mode_sel,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic             busy,
  output logic             done,
  output logic             crc_ok,
  output logic [31:0]      crc_out
);
  import crc32_serial_pkg::*;

  // Named internal events, visible to the bound checker.
  logic             take;
  logic             last_take;
  logic             rx_mode;
  logic [CRC_W-1:0] lfsr_state;
  logic [CRC_W-1:0] lfsr_next;

  assign take = busy && bit_vld && !start;

  crc_len_tracker #(
    .MIN_BITS (MIN_MSG_BITS),
    .MAX_BITS (MAX_MSG_BITS),
    .TAIL_BITS(CRC_W),
    .LEN_W    (LEN_W)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rx_req   (rx_mode_sel),
    .len_req  (msg_len),
    .take     (take),
    .busy     (busy),
    .rx_mode  (rx_mode),
    .last_take(last_take)
  );

  crc_lfsr #(
    .W     (CRC_W),
    .POLY  (CRC_POLY),
    .PRESET(CRC_PRESET)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .shift    (take),
    .din      (bit_in),
    .state    (lfsr_state),
    .state_nxt(lfsr_next)
  );

  crc_result_stage #(
    .W      (CRC_W),
    .RESIDUE(CRC_RESIDUE)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .last_take(last_take),
    .rx_mode  (rx_mode),
    .state_nxt(lfsr_next),
    .done     (done),
    .crc_ok   (crc_ok)
  );

  assign crc_out = ~lfsr_state;

endmodule

// File: rtl/crc32_serial_chk.sv
module crc32_serial_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bit_vld,
  input logic        busy,
  input logic        done,
  input logic        crc_ok,
  input logic [31:0] crc_out,
  input logic        take,
  input logic        last_take,
  input logic        rx_mode
);

  AST_PRESET_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_out == 32'h0 && busy)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> done); // R4
  AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_take)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc_out)); // R6
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !take); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_vld && !start) |=> $stable(crc_out)); // R7
  AST_OK_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> rx_mode); // R10

endmodule

bind crc32_serial_engine crc32_serial_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .bit_vld  (bit_vld),
  .busy     (busy),
  .done     (done),
  .crc_ok   (crc_ok),
  .crc_out  (crc_out),
  .take     (take),
  .last_take(last_take),
  .rx_mode  (rx_mode)
);

// File: tb/tb_crc32_serial_engine.sv
module tb_crc32_serial_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rx_mode_sel = 1'b0;
  logic [6:0]  msg_len = '0;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic        busy, done, crc_ok;
  logic [31:0] crc_out;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  crc32_serial_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode_sel(rx_mode_sel),
    .msg_len(msg_len), .bit_in(bit_in), .bit_vld(bit_vld),
    .busy(busy), .done(done), .crc_ok(crc_ok), .crc_out(crc_out)
  );

  // Vector fields: {rx, corrupt, gaps, len[6:0], data[63:0]}
  localparam logic [73:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 7'd12,  64'h0000_0000_0000_0ABC},
    {1'b0, 1'b0, 1'b0, 7'd64,  64'hDEAD_BEEF_0123_4567},
    {1'b0, 1'b0, 1'b1, 7'd33,  64'h0000_0001_5A5A_A5A5},
    {1'b0, 1'b0, 1'b0, 7'd3,   64'h0000_0000_0000_0F0F},
    {1'b0, 1'b0, 1'b0, 7'd100, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b0, 1'b0, 7'd12,  64'h0000_0000_0000_0123},
    {1'b1, 1'b0, 1'b1, 7'd64,  64'h8000_0000_0000_0001},
    {1'b1, 1'b1, 1'b0, 7'd40,  64'h0000_00C3_3C96_6900},
    {1'b1, 1'b0, 1'b0, 7'd27,  64'h0000_0000_0765_4321},
    {1'b1, 1'b1, 1'b1, 7'd64,  64'h0000_0000_0000_0000}
  };

  function automatic int eff_len(input int req);
    if (req < 12) return 12;
    if (req > 64) return 64;
    return req;
  endfunction

  // Reflected-form model: right shift, mirrored polynomial.
  function automatic logic [31:0] mirror_run(input logic [95:0] s, input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      logic fb = r[0] ^ s[i];
      r = (r >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = v[31-i];
    return o;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic rxm, input int lreq);
    @(negedge clk);
    start = 1'b1; rx_mode_sel = rxm; msg_len = 7'(lreq); bit_vld = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input logic rxm, input logic bad, input logic gap,
                           input int lreq, input logic [63:0] data);
    int L = eff_len(lreq);
    int n = rxm ? L + 32 : L;
    logic [95:0] st = '0;
    logic [31:0] s_msg, word, s_all;
    for (int i = 0; i < L; i++) st[i] = data[i];
    s_msg = mirror_run(st, L);
    word  = rev32(~s_msg);
    if (rxm) begin
      for (int k = 0; k < 32; k++) st[L+k] = word[31-k];
      if (bad) st[3] = ~st[3];
    end
    s_all = mirror_run(st, n);
    pulse_start(rxm, lreq);
    check(busy == 1'b1 && crc_out == 32'h0, "R2 preset", crc_out, 32'h0);
    for (int i = 0; i < n; i++) begin
      if (gap && (i % 3 == 1)) begin
        bit_vld = 1'b0; bit_in = ~st[i];
        @(negedge clk);
      end
      bit_in = st[i]; bit_vld = 1'b1;
      @(negedge clk);
    end
    bit_vld = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R4 done", {30'b0, done, busy}, 32'h2);
    if (!rxm) begin
      check(crc_out == word, "R4 crc word", crc_out, word);
      check(crc_ok == 1'b0, "R10 ok low in tx", {31'b0, crc_ok}, 32'h0);
    end else begin
      check(crc_ok == (s_all == 32'hDEBB_20E3), "R5 residue", {31'b0, crc_ok},
            {31'b0, (s_all == 32'hDEBB_20E3)});
      check(bad || crc_out == 32'h38FB_2284, "R5 residue word", crc_out, 32'h38FB_2284);
    end
    @(negedge clk);
    check(done == 1'b0, "R4 single pulse", {31'b0, done}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && crc_ok == 0 && crc_out == 0, "R1 reset",
          crc_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && crc_out == 0, "R1 after reset", crc_out, 32'h0);

    // R6 idle bits before any start
    for (int i = 0; i < 4; i++) begin
      bit_in = i[0]; bit_vld = 1'b1;
      @(negedge clk);
      check(crc_out == 0 && done == 0, "R6 idle ignore", crc_out, 32'h0);
    end
    bit_vld = 1'b0;

    // Table walk: R3 R4 R5 R7 R8 R10
    foreach (VEC[v])
      run_frame(VEC[v][73], VEC[v][72], VEC[v][71], int'(VEC[v][70:64]), VEC[v][63:0]);

    // R6 overrun bits after a transmit message
    run_frame(1'b0, 1'b0, 1'b0, 20, 64'h000A_BCDE);
    held = crc_out;
    for (int i = 0; i < 5; i++) begin
      bit_in = ~i[0]; bit_vld = 1'b1;
      @(negedge clk);
      check(crc_out == held && done == 0, "R6 overrun ignored", crc_out, held);
    end
    bit_vld = 1'b0;

    // R9 restart during a message
    pulse_start(1'b0, 40);
    for (int i = 0; i < 7; i++) begin
      bit_in = 1'b1; bit_vld = 1'b1;
      @(negedge clk);
    end
    bit_vld = 1'b0;
    check(busy == 1'b1, "R9 still busy", {31'b0, busy}, 32'h1);
    run_frame(1'b0, 1'b0, 1'b0, 16, 64'h0000_0000_0000_C001);

    // R1 reset mid message
    pulse_start(1'b1, 30);
    bit_in = 1'b1; bit_vld = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; bit_vld = 1'b0;
    @(negedge clk);
    check(busy == 0 && crc_out == 0 && crc_ok == 0, "R1 reset mid", crc_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule